// File: doc/BRIEF.md
# Two-Wire Shift Unit with Clock Stretching

This block is the bit-level engine of a two-wire serial bus target. It watches the clock and data lines of the bus, shifts the data line into an 8-bit register on every rising clock edge, and counts both clock edges in a 4-bit counter. The counter can be preloaded, so one transfer is either a full byte (preload 0, sixteen edges) or a single acknowledge slot (preload 14, two edges). A start-condition detector and a stop-condition detector report bus framing, and a collision flag reports a released data line that another device pulled low.

The unit can stretch the clock by holding it low. It does so while a detected start is pending, and also while a counter overflow is pending when the hold-on-overflow mode is selected. Firmware or a sequencing controller reads the status, moves the next byte in or out through the data register, and clears the matching flag, which releases the clock. Addressing, buffering and the transaction sequence are done by that controller, not here.

Both bus lines are open-drain: the block only ever asks for a line to be pulled low. The data line is driven from a one-bit output latch that takes the register MSB at each falling clock edge and on every data write, so the driven level never changes while the clock is high.

Top module: `tw_shift_unit`

## Requirements
- R1: After reset the data register, the counter, all status flags and the configuration are zero, and neither line is pulled low.
- R2: While enabled, each rising SCL edge moves the data register one place toward bit 7 and puts the sampled SDA level in bit 0, so eight rising edges leave the byte in the register with the first bit in bit 7; a data write replaces the register.
- R3: While enabled and no start is pending, the counter (status bits 3:0) advances by one on each rising and each falling SCL edge; stepping from 15 wraps it to 0 and sets the overflow flag (status bit 6). A full byte from preload 0 therefore sets overflow on its sixteenth edge.
- R4: A status write loads status bits 3:0 of the written value into the counter; a preload of 14 overflows after one clock pulse (two edges).
- R5: While enabled, SDA falling while SCL is high sets the start flag (status bit 7), and SCL is held low (sclHoldLow = 1) for as long as that flag is set.
- R6: With the hold-on-overflow mode (configuration bit 1) set, SCL is also held low while the overflow flag is set; with that bit clear, an overflow never holds SCL.
- R7: While enabled, SDA rising while SCL is high sets the stop flag (status bit 5); a stop never holds SCL.
- R8: A status write clears each flag whose bit is written as 1 and leaves a flag whose bit is written as 0 unchanged; in particular writing 0 to bit 7 leaves a pending start pending.
- R9: startIrq is high exactly while the start flag and the start-interrupt enable (configuration bit 2) are both set; ovfIrq likewise with the overflow flag and configuration bit 3.
- R10: With the unit enabled and the SDA output enable (configuration bit 4) set, sdaPullLow is high while the output latch is 0; the latch takes the data register MSB on each falling SCL edge and the new bit 7 on each data write.
- R11: The collision flag (status bit 4) is set at a rising SCL edge when the unit is enabled, the SDA output is enabled, the output latch is 1 (line released), and SDA is sampled low.
- R12: With the unit enable (configuration bit 0) clear, line activity changes no flag, the counter or the data register, and neither line is pulled low.
- R13: Each line passes through two synchronising flops and an edge register, so a line change made before a clock edge alters the counter, flags and data register at the third clock edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Level of the bus clock line |
| sdaIn | input | 1 | Level of the bus data line |
| sclHoldLow | output | 1 | 1 = pull the clock line low (stretch) |
| sdaPullLow | output | 1 | 1 = pull the data line low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWrData | input | 5 | Configuration value: bit0 enable, bit1 hold-on-overflow, bit2 start interrupt enable, bit3 overflow interrupt enable, bit4 SDA output enable |
| cfgQ | output | 5 | Current configuration |
| dataWe | input | 1 | Data register write strobe |
| dataWrData | input | 8 | Value written to the data register |
| dataQ | output | 8 | Data register contents |
| statWe | input | 1 | Status write strobe (flag clear and counter preload) |
| statWrData | input | 8 | bits 7..4 write-one-to-clear start, overflow, stop, collision; bits 3..0 counter preload |
| statusQ | output | 8 | bit7 start, bit6 overflow, bit5 stop, bit4 collision, bits 3..0 counter |
| startIrq | output | 1 | Start interrupt request |
| ovfIrq | output | 1 | Overflow interrupt request |

## Verification
The main function is tried with a received byte of mixed bits (0xA5) clocked in from preload 0, a one-pulse acknowledge slot from preload 14 with the data line driven low by the unit, and a transmitted byte (0xB1) where the unit itself drives every bit; the first separates shift direction and bit order, the second separates the single-bit preload from the byte count, and the third shows that the driven level changes only while the clock is low, since any change while high would raise a false start or stop. A deliberate clash, with the master pulling the line low under a released bit, isolates the collision flag. The same edge sequences are repeated with the hold-on-overflow mode off and with the unit disabled, which separates the stretching and gating from the counting itself, and a single edge timed against the clock pins the synchroniser latency.

// File: rtl/tw_shift_pkg.sv
package tw_shift_pkg;

  // configuration register field positions
  localparam int CFG_W        = 5;
  localparam int CFG_EN       = 0;
  localparam int CFG_HOLD_OVF = 1;
  localparam int CFG_START_IE = 2;
  localparam int CFG_OVF_IE   = 3;
  localparam int CFG_SDA_OE   = 4;

  // status flag positions (above the counter field)
  localparam int FLAG_N     = 4;
  localparam int FLAG_COLL  = 0;
  localparam int FLAG_STOP  = 1;
  localparam int FLAG_OVF   = 2;
  localparam int FLAG_START = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;     // shift one sampled bit into the data register
    logic step;      // advance the edge counter
    logic loadCnt;   // preload the edge counter
    logic loadData;  // replace the data register
  } dpStrobe_t;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              lastLevel;

  // bus lines idle high, so the chain resets to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain     <= '1;
      lastLevel <= 1'b1;
    end else begin
      chain     <= {chain[STAGES-2:0], lineIn};
      lastLevel <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~lastLevel;
  assign fall  = ~chain[STAGES-1] & lastLevel;

endmodule

// File: rtl/tw_datapath.sv
module tw_datapath
  import tw_shift_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaBit,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  preload,
  output logic [DATA_W-1:0] dataQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic              cntAtMax
);

  logic [DATA_W-1:0] dataR;
  logic [CNT_W-1:0]  cntR;

  // shift register: a write wins over a shift in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataR <= '0;
    end else if (stb.loadData) begin
      dataR <= wrData;
    end else if (stb.shift) begin
      dataR <= {dataR[DATA_W-2:0], sdaBit};
    end
  end

  // edge counter: a preload wins over a step in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntR <= '0;
    end else if (stb.loadCnt) begin
      cntR <= preload;
    end else if (stb.step) begin
      cntR <= cntR + 1'b1;
    end
  end

  assign dataQ    = dataR;
  assign cntQ     = cntR;
  assign cntAtMax = &cntR;

endmodule

// File: rtl/tw_control.sv
module tw_control
  import tw_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclLevel,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaLevel,
  input  logic              sdaRise,
  input  logic              sdaFall,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              dataWe,
  input  logic              dataWrMsb,
  input  logic              statWe,
  input  logic [FLAG_N-1:0] statWrFlags,
  input  logic              cntAtMax,
  input  logic              dataMsb,
  output dpStrobe_t         stb,
  output logic [CFG_W-1:0]  cfgQ,
  output logic [FLAG_N-1:0] flagQ,
  output logic              sclHoldLow,
  output logic              sdaPullLow,
  output logic              startIrq,
  output logic              ovfIrq
);

  logic [CFG_W-1:0]  cfgR;
  logic [FLAG_N-1:0] flagSet;
  logic              outLatch;
  logic              unitOn;
  logic              startPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgR <= '0;
    end else if (cfgWe) begin
      cfgR <= cfgWrData;
    end
  end

  assign unitOn    = cfgR[CFG_EN];
  assign startPend = flagQ[FLAG_START];

  // strobes toward the datapath; counting pauses while a start is pending
  always_comb begin
    stb.shift    = unitOn & sclRise;
    stb.step     = unitOn & (sclRise | sclFall) & ~startPend;
    stb.loadCnt  = statWe;
    stb.loadData = dataWe;
  end

  // events that raise each flag
  always_comb begin
    flagSet              = '0;
    flagSet[FLAG_START]  = unitOn & sclLevel & sdaFall;
    flagSet[FLAG_STOP]   = unitOn & sclLevel & sdaRise;
    flagSet[FLAG_OVF]    = stb.step & cntAtMax;
    flagSet[FLAG_COLL]   = unitOn & sclRise & cfgR[CFG_SDA_OE] & outLatch & ~sdaLevel;
  end

  // write-one-to-clear flags; a raising event wins over a clear
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic flagBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagBit <= 1'b0;
      end else begin
        flagBit <= flagSet[i] | (flagBit & ~(statWe & statWrFlags[i]));
      end
    end
    assign flagQ[i] = flagBit;
  end

  // SDA output latch: changes only on a write or while SCL has just fallen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= 1'b0;
    end else if (dataWe) begin
      outLatch <= dataWrMsb;
    end else if (unitOn & sclFall) begin
      outLatch <= dataMsb;
    end
  end

  assign cfgQ       = cfgR;
  assign sclHoldLow = unitOn & (startPend | (cfgR[CFG_HOLD_OVF] & flagQ[FLAG_OVF]));
  assign sdaPullLow = unitOn & cfgR[CFG_SDA_OE] & ~outLatch;
  assign startIrq   = startPend & cfgR[CFG_START_IE];
  assign ovfIrq     = flagQ[FLAG_OVF] & cfgR[CFG_OVF_IE];

endmodule

// File: rtl/tw_shift_unit.sv
module tw_shift_unit
  import tw_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  output logic                    sclHoldLow,
  output logic                    sdaPullLow,
  input  logic                    cfgWe,
  input  logic [CFG_W-1:0]        cfgWrData,
  output logic [CFG_W-1:0]        cfgQ,
  input  logic                    dataWe,
  input  logic [DATA_W-1:0]       dataWrData,
  output logic [DATA_W-1:0]       dataQ,
  input  logic                    statWe,
  input  logic [FLAG_N+CNT_W-1:0] statWrData,
  output logic [FLAG_N+CNT_W-1:0] statusQ,
  output logic                    startIrq,
  output logic                    ovfIrq
);

  localparam int STAT_W = FLAG_N + CNT_W;

  logic              sclLevel, sclRise, sclFall;
  logic              sdaLevel, sdaRise, sdaFall;
  logic              cntAtMax;
  logic [CNT_W-1:0]  cntQ;
  logic [FLAG_N-1:0] flagQ;
  dpStrobe_t         stb;

  tw_line_sync #(.STAGES(SYNC_STAGES)) sclSync_i (
    .clk(clk), .rstN(rstN), .lineIn(sclIn),
    .level(sclLevel), .rise(sclRise), .fall(sclFall)
  );

  tw_line_sync #(.STAGES(SYNC_STAGES)) sdaSync_i (
    .clk(clk), .rstN(rstN), .lineIn(sdaIn),
    .level(sdaLevel), .rise(sdaRise), .fall(sdaFall)
  );

  tw_control ctrl_i (
    .clk(clk), .rstN(rstN),
    .sclLevel(sclLevel), .sclRise(sclRise), .sclFall(sclFall),
    .sdaLevel(sdaLevel), .sdaRise(sdaRise), .sdaFall(sdaFall),
    .cfgWe(cfgWe), .cfgWrData(cfgWrData),
    .dataWe(dataWe), .dataWrMsb(dataWrData[DATA_W-1]),
    .statWe(statWe), .statWrFlags(statWrData[STAT_W-1:CNT_W]),
    .cntAtMax(cntAtMax), .dataMsb(dataQ[DATA_W-1]),
    .stb(stb), .cfgQ(cfgQ), .flagQ(flagQ),
    .sclHoldLow(sclHoldLow), .sdaPullLow(sdaPullLow),
    .startIrq(startIrq), .ovfIrq(ovfIrq)
  );

  tw_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaLevel),
    .wrData(dataWrData), .preload(statWrData[CNT_W-1:0]),
    .dataQ(dataQ), .cntQ(cntQ), .cntAtMax(cntAtMax)
  );

  assign statusQ = {flagQ, cntQ};

endmodule

// File: rtl/tw_shift_unit_chk.sv
module tw_shift_unit_chk #(
  parameter int CFG_W  = 5,
  parameter int STAT_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              statWe,
  input logic [STAT_W-1:0] statWrData,
  input logic [STAT_W-1:0] statusQ,
  input logic [CFG_W-1:0]  cfgQ,
  input logic              sclHoldLow,
  input logic              sdaPullLow
);

  localparam int ST_START = STAT_W - 1;
  localparam int ST_OVF   = STAT_W - 2;

  logic [CNT_W-1:0] cnt;
  assign cnt = statusQ[CNT_W-1:0];

  // R8
  start_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWe && !statWrData[ST_START] && statusQ[ST_START]) |=> statusQ[ST_START]);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statWe |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(statWe) && $rose(statusQ[ST_OVF])) |-> (cnt == '0));

  // R6
  no_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgQ[1] && !statusQ[ST_START]) |-> !sclHoldLow);

  // R12
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ[0] |-> (!sclHoldLow && !sdaPullLow));

endmodule

bind tw_shift_unit tw_shift_unit_chk #(
  .CFG_W(tw_shift_pkg::CFG_W), .STAT_W(STAT_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .statWe(statWe), .statWrData(statWrData),
  .statusQ(statusQ), .cfgQ(cfgQ), .sclHoldLow(sclHoldLow), .sdaPullLow(sdaPullLow)
);

// File: tb/tw_shift_unit_tb_top.sv
module tw_shift_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclIn = 1'b1, sdaIn = 1'b1;
  logic       sclHoldLow, sdaPullLow;
  logic       cfgWe = 1'b0;
  logic [4:0] cfgWrData = '0;
  logic [4:0] cfgQ;
  logic       dataWe = 1'b0;
  logic [7:0] dataWrData = '0;
  logic [7:0] dataQ;
  logic       statWe = 1'b0;
  logic [7:0] statWrData = '0;
  logic [7:0] statusQ;
  logic       startIrq, ovfIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_shift_unit dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclHoldLow(sclHoldLow), .sdaPullLow(sdaPullLow),
    .cfgWe(cfgWe), .cfgWrData(cfgWrData), .cfgQ(cfgQ),
    .dataWe(dataWe), .dataWrData(dataWrData), .dataQ(dataQ),
    .statWe(statWe), .statWrData(statWrData), .statusQ(statusQ),
    .startIrq(startIrq), .ovfIrq(ovfIrq)
  );

  int  nTests = 0;
  int  nFails = 0;
  bit  finished = 0;

  // master intent and pending register writes
  bit       wantScl = 1, wantSda = 1;
  bit       pCfgWe = 0, pDataWe = 0, pStatWe = 0;
  bit [4:0] pCfg = 0;
  bit [7:0] pData = 0, pStat = 0;

  // behavioural reference state
  int mData = 0, mCnt = 0, mCfg = 0;
  bit mStart = 0, mOvf = 0, mStop = 0, mColl = 0, mLatch = 0;
  bit sclH[$] = '{1, 1, 1, 1};
  bit sdaH[$] = '{1, 1, 1, 1};

  task automatic chk(string tag, int got, int exp);
    nTests++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit en;
    en = mCfg[0];
    chk("R2 data register", int'(dataQ), mData);
    chk("R3 counter", int'(statusQ[3:0]), mCnt);
    chk("R5 start flag", int'(statusQ[7]), int'(mStart));
    chk("R3 overflow flag", int'(statusQ[6]), int'(mOvf));
    chk("R7 stop flag", int'(statusQ[5]), int'(mStop));
    chk("R11 collision flag", int'(statusQ[4]), int'(mColl));
    chk("R6 clock hold", int'(sclHoldLow), int'(en && (mStart || (mCfg[1] && mOvf))));
    chk("R10 data pull", int'(sdaPullLow), int'(en && mCfg[4] && !mLatch));
    chk("R9 start irq", int'(startIrq), int'(mStart && mCfg[2]));
    chk("R9 overflow irq", int'(ovfIrq), int'(mOvf && mCfg[3]));
  endtask

  task automatic modelStep();
    bit sNow, sPrev, dNow, dPrev, sr, sf, dr, df, en, stepC;
    int nData, nCnt;
    bit nLatch;
    sclH.push_back(sclIn);
    sdaH.push_back(sdaIn);
    sNow = sclH[2]; sPrev = sclH[1];
    dNow = sdaH[2]; dPrev = sdaH[1];
    void'(sclH.pop_front());
    void'(sdaH.pop_front());
    sr = sNow && !sPrev; sf = !sNow && sPrev;
    dr = dNow && !dPrev; df = !dNow && dPrev;
    en = mCfg[0];
    stepC = en && (sr || sf) && !mStart;
    nData  = dataWe ? int'(dataWrData) : (en && sr) ? (((mData << 1) | int'(dNow)) & 255) : mData;
    nLatch = dataWe ? dataWrData[7] : (en && sf) ? mData[7] : mLatch;
    nCnt   = statWe ? int'(statWrData[3:0]) : stepC ? ((mCnt + 1) % 16) : mCnt;
    mColl  = (en && sr && mCfg[4] && mLatch && !dNow) || (mColl && !(statWe && statWrData[4]));
    mStop  = (en && sNow && dr) || (mStop && !(statWe && statWrData[5]));
    mOvf   = (stepC && mCnt == 15) || (mOvf && !(statWe && statWrData[6]));
    mStart = (en && sNow && df) || (mStart && !(statWe && statWrData[7]));
    mData = nData; mLatch = nLatch; mCnt = nCnt;
    if (cfgWe) mCfg = int'(cfgWrData);
  endtask

  // one clock: compare, drive the bus and strobes, advance the model
  task automatic cyc(int n = 1);
    repeat (n) begin
      @(negedge clk);
      compareAll();
      sclIn = wantScl & ~sclHoldLow;
      sdaIn = wantSda & ~sdaPullLow;
      cfgWe = pCfgWe;   cfgWrData  = pCfg;
      dataWe = pDataWe; dataWrData = pData;
      statWe = pStatWe; statWrData = pStat;
      modelStep();
      pCfgWe = 0; pDataWe = 0; pStatWe = 0;
    end
  endtask

  task automatic writeCfg(bit [4:0] v);
    pCfgWe = 1; pCfg = v; cyc(1);
  endtask
  task automatic writeData(bit [7:0] v);
    pDataWe = 1; pData = v; cyc(1);
  endtask
  task automatic writeStat(bit [7:0] v);
    pStatWe = 1; pStat = v; cyc(1);
  endtask
  task automatic bitClock(bit b);
    wantSda = b; cyc(4);
    wantScl = 1; cyc(4);
    wantScl = 0; cyc(4);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nTests++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    bit [7:0] rxByte;
    bit [7:0] keepData;
    int cntBefore;
    rxByte = 8'hA5;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", int'(statusQ), 0);
    chk("R1 data", int'(dataQ), 0);
    chk("R1 config", int'(cfgQ), 0);
    chk("R1 lines released", int'({sclHoldLow, sdaPullLow}), 0);
    chk("R1 irqs", int'({startIrq, ovfIrq}), 0);

    // enable, hold on overflow, both interrupts
    writeCfg(5'h0F);
    cyc(6);
    // start condition
    wantSda = 0; cyc(6);
    chk("R5 start flagged", int'(statusQ), 8'h80);
    chk("R5 clock held after start", int'(sclHoldLow), 1);
    chk("R9 start irq", int'(startIrq), 1);
    wantScl = 0; cyc(2);
    writeStat(8'h00); cyc(4);
    chk("R8 zero write keeps start", int'(statusQ[7]), 1);
    writeStat(8'h80); cyc(4);
    chk("R8 one write clears start", int'(statusQ), 8'h00);
    chk("R5 hold released", int'(sclHoldLow), 0);

    // receive a byte, MSB first
    for (int i = 7; i >= 0; i--) begin
      bitClock(rxByte[i]);
      if (i > 0) chk("R3 edges counted", int'(statusQ[3:0]), (2 * (8 - i)) % 16);
    end
    chk("R2 received byte", int'(dataQ), 8'hA5);
    chk("R3 overflow after 16 edges", int'(statusQ), 8'h40);
    chk("R6 clock held on overflow", int'(sclHoldLow), 1);
    chk("R9 overflow irq", int'(ovfIrq), 1);

    // acknowledge slot driven by the unit
    writeData(8'h00);
    writeCfg(5'h1F);
    cyc(3);
    chk("R10 ack pulls data low", int'(sdaPullLow), 1);
    writeStat(8'h4E); cyc(3);
    chk("R4 preload 14", int'(statusQ), 8'h0E);
    bitClock(1);
    chk("R4 one-bit overflow", int'(statusQ), 8'h40);

    // transmit a byte driven by the unit
    writeData(8'hB1);
    cyc(3);
    chk("R10 released for MSB 1", int'(sdaPullLow), 0);
    writeStat(8'h40);
    for (int i = 0; i < 8; i++) bitClock(1);
    chk("R2 transmitted byte loops back", int'(dataQ), 8'hB1);
    chk("R11 no collision on own bits", int'(statusQ), 8'h40);

    // collision: master pulls a released bit low
    writeData(8'h80);
    writeStat(8'h4E);
    bitClock(0);
    chk("R11 collision flagged", int'(statusQ), 8'h50);

    // stop condition, no output drive
    writeCfg(5'h0F);
    writeStat(8'hF0);
    cyc(3);
    wantScl = 1; cyc(4);
    wantSda = 1; cyc(4);
    chk("R7 stop flagged", int'(statusQ), 8'h21);
    chk("R7 stop does not hold", int'(sclHoldLow), 0);

    // overflow without hold mode
    writeCfg(5'h01);
    writeStat(8'hFF);
    wantScl = 0; cyc(5);
    chk("R6 overflow set without hold", int'(statusQ), 8'h40);
    chk("R6 no hold in plain mode", int'(sclHoldLow), 0);
    chk("R9 overflow irq gated", int'(ovfIrq), 0);

    // disabled unit ignores the bus
    writeCfg(5'h00);
    writeStat(8'hF3);
    cyc(3);
    keepData = dataQ;
    wantScl = 1; cyc(4);
    wantSda = 0; cyc(4);
    wantSda = 1; cyc(4);
    wantScl = 0; cyc(4);
    chk("R12 status untouched when off", int'(statusQ), 8'h03);
    chk("R12 data untouched when off", int'(dataQ), int'(keepData));
    chk("R12 no hold when off", int'(sclHoldLow), 0);

    // synchroniser latency
    writeCfg(5'h01);
    writeStat(8'h00);
    cyc(4);
    cntBefore = int'(statusQ[3:0]);
    wantScl = 1; cyc(1);
    cyc(1);
    cyc(1);
    chk("R13 no count after two edges", int'(statusQ[3:0]), cntBefore);
    cyc(1);
    chk("R13 count at third edge", int'(statusQ[3:0]), (cntBefore + 1) % 16);
    cyc(4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule